// File: doc/BRIEF.md
# Split-Mode Dual 8-bit Timer Pair

This block holds two 16-bit counter/timers. Each can run as a 13-bit prescaler-style counter, a plain 16-bit counter, or an 8-bit counter that reloads itself from its upper byte. Each counter advances on one of three sources: every system clock, a prescaled tick, or rising edges on an external count pin. Each overflow latches a sticky flag, which software clears with a one-cycle strobe.

Setting timer 0 to mode 3 splits it into two free 8-bit counters. The low byte keeps all of timer 0's controls: run, gate, counter select and flag 0. The high byte acts only as a timer and takes over timer 1's run bit and flag 1. In that case timer 1 runs whenever its mode is not 3. It ignores its run bit and its count pin, and it never sets flag 1. It still emits its one-cycle overflow pulse, which serial baud logic or an ADC trigger can use.

A 16-bit load strobe per timer writes the whole count, so the counter can be preset.

Top module: `split_timer_pair`

## Requirements
- R1: While `rst_n` is low, both counts, both flags and `t1_ovf` are 0.
- R2: In mode 1 a counter counts through 16 bits. From 0xFFFF it wraps to 0x0000 and sets its flag on that same edge.
- R3: In mode 0 a counter is 13 bits wide: the upper byte plus bits [4:0] of the lower byte. A carry out of bit 4 increments the upper byte, and bits [7:5] never change. Going from upper 0xFF with low field 0x1F clears both and sets the flag.
- R4: In mode 2 the lower byte counts. When it steps from 0xFF, it is loaded with the upper byte and the flag is set, while the upper byte stays as it is.
- R5: Timer 0, and the split low byte, advances only when `t0_run` is 1 and either `t0_gate` is 0 or `gate_pin ^ gate_pol` is 1. The gate pin passes through a two-flop synchronizer first.
- R6: When the external-count select is 1, the counter advances once per rising edge of its count pin, detected after a two-flop synchronizer.
- R7: With `tN_clksel` = 1, the internal timebase is `tick_pre`; with 0 it is every clock.
- R8: With `t0_mode` = 3, bits [7:0] of timer 0 form an 8-bit counter under timer 0's controls. It wraps 0xFF to 0x00 and sets `flag0`.
- R9: With `t0_mode` = 3, bits [15:8] of timer 0 form an 8-bit timer. It is enabled by `t1_run`, clocked through `t0_clksel`, and its wrap sets `flag1`.
- R10: With `t0_mode` = 3, timer 1 counts whenever `t1_mode` is not 3, whatever the value of `t1_run`. It uses only the internal timebase and does not set `flag1`. With `t1_mode` = 3 it holds.
- R11: A flag stays set until a clear strobe. An overflow and a clear on the same edge leave the flag set.
- R12: A load strobe writes `ld_val` into the whole count on the next edge. The load takes precedence over counting and raises no flag.
- R13: `t1_out` pulses for one cycle on the edge where timer 1 overflows, in every timer 0 mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_pre | input | 1 | Prescaled timebase enable, one cycle wide |
| cnt0_pin | input | 1 | External count input, timer 0 |
| cnt1_pin | input | 1 | External count input, timer 1 |
| gate_pin | input | 1 | External gate input for timer 0 |
| gate_pol | input | 1 | Gate polarity: active level is `gate_pin ^ gate_pol` = 1 |
| t0_mode | input | 2 | Timer 0 mode: 0 = 13-bit, 1 = 16-bit, 2 = 8-bit reload, 3 = split |
| t0_run | input | 1 | Timer 0 run |
| t0_ext | input | 1 | Timer 0 counts pin edges when 1 |
| t0_gate | input | 1 | Timer 0 gate enable |
| t0_clksel | input | 1 | Timer 0 and split high-byte timebase: 1 = `tick_pre` |
| t1_mode | input | 2 | Timer 1 mode: 0, 1, 2 as timer 0; 3 = stopped |
| t1_run | input | 1 | Timer 1 run, or split high-byte run |
| t1_ext | input | 1 | Timer 1 counts pin edges when 1 (not in split) |
| t1_clksel | input | 1 | Timer 1 timebase: 1 = `tick_pre` |
| ld0 | input | 1 | Load strobe for timer 0 |
| ld1 | input | 1 | Load strobe for timer 1 |
| ld_val | input | 16 | Load value |
| clr_f0 | input | 1 | Clear strobe for `flag0` |
| clr_f1 | input | 1 | Clear strobe for `flag1` |
| t0_cnt | output | 16 | Timer 0 count (high byte, low byte) |
| t1_cnt | output | 16 | Timer 1 count |
| flag0 | output | 1 | Timer 0 / split low-byte overflow flag |
| flag1 | output | 1 | Timer 1 / split high-byte overflow flag |
| t1_ovf | output | 1 | Timer 1 overflow pulse |

## Verification
Counts, flags and the overflow pulse all change on the clock edge that applies an enabled increment or a load. The bench therefore waits exactly N rising edges after enabling a counter and samples on the following falling edge. Gate changes take effect from the third edge after the pin moves, and pin edges are counted on the third edge after the rise. Windows that use these inputs are padded by whole cycles, and the expected counts include that latency.

// File: rtl/split_timer_pair.sv
module split_timer_pair (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick_pre,
  input  logic        cnt0_pin,
  input  logic        cnt1_pin,
  input  logic        gate_pin,
  input  logic        gate_pol,
  input  logic [1:0]  t0_mode,
  input  logic        t0_run,
  input  logic        t0_ext,
  input  logic        t0_gate,
  input  logic        t0_clksel,
  input  logic [1:0]  t1_mode,
  input  logic        t1_run,
  input  logic        t1_ext,
  input  logic        t1_clksel,
  input  logic        ld0,
  input  logic        ld1,
  input  logic [15:0] ld_val,
  input  logic        clr_f0,
  input  logic        clr_f1,
  output logic [15:0] t0_cnt,
  output logic [15:0] t1_cnt,
  output logic        flag0,
  output logic        flag1,
  output logic        t1_ovf
);

  function automatic logic [16:0] step(input logic [1:0] m, input logic [15:0] v);
    case (m)
      2'd0:
        if (v[4:0] == 5'h1F) step = {v[15:8] == 8'hFF, v[15:8] + 8'd1, v[7:5], 5'd0};
        else                 step = {1'b0, v[15:5], v[4:0] + 5'd1};
      2'd1:    step = {v == 16'hFFFF, v + 16'd1};
      2'd2:
        if (v[7:0] == 8'hFF) step = {1'b1, v[15:8], v[15:8]};
        else                 step = {1'b0, v[15:8], v[7:0] + 8'd1};
      default: step = {1'b0, v};
    endcase
  endfunction

  logic [2:0] s0, s1;
  logic [1:0] sg;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      s0 <= '0; s1 <= '0; sg <= '0;
    end else begin
      s0 <= {s0[1:0], cnt0_pin};
      s1 <= {s1[1:0], cnt1_pin};
      sg <= {sg[0], gate_pin};
    end

  wire split  = (t0_mode == 2'd3);
  wire tick0  = t0_clksel ? tick_pre : 1'b1;
  wire tick1  = t1_clksel ? tick_pre : 1'b1;
  wire rise0  = s0[1] & ~s0[2];
  wire rise1  = s1[1] & ~s1[2];
  wire en0    = t0_run & (~t0_gate | (sg[1] ^ gate_pol));
  wire inc0   = en0 & (t0_ext ? rise0 : tick0);
  wire inc_hi = split & t1_run & tick0;
  wire go1    = (t1_mode != 2'd3) & (split | t1_run);
  wire inc1   = go1 & ((t1_ext & ~split) ? rise1 : tick1);

  wire [16:0] nx0   = step(t0_mode, t0_cnt);
  wire [16:0] nx1   = step(t1_mode, t1_cnt);
  wire [8:0]  lo_nx = {1'b0, t0_cnt[7:0]} + 9'd1;
  wire [8:0]  hi_nx = {1'b0, t0_cnt[15:8]} + 9'd1;

  wire ovf0   = ~ld0 & inc0 & (split ? lo_nx[8] : nx0[16]);
  wire ovf_hi = ~ld0 & inc_hi & hi_nx[8];
  wire ovf1   = ~ld1 & inc1 & nx1[16];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) t0_cnt <= '0;
    else if (ld0) t0_cnt <= ld_val;
    else if (split) begin
      if (inc0)   t0_cnt[7:0]  <= lo_nx[7:0];
      if (inc_hi) t0_cnt[15:8] <= hi_nx[7:0];
    end else if (inc0) t0_cnt <= nx0[15:0];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)    t1_cnt <= '0;
    else if (ld1)  t1_cnt <= ld_val;
    else if (inc1) t1_cnt <= nx1[15:0];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      flag0  <= 1'b0;
      flag1  <= 1'b0;
      t1_ovf <= 1'b0;
    end else begin
      flag0  <= ovf0 | (flag0 & ~clr_f0);
      flag1  <= ovf_hi | (ovf1 & ~split) | (flag1 & ~clr_f1);
      t1_ovf <= ovf1;
    end

endmodule

module split_timer_pair_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [1:0]  t0_mode,
  input logic        t0_run,
  input logic        t1_run,
  input logic        ld0,
  input logic [15:0] ld_val,
  input logic        clr_f0,
  input logic [15:0] t0_cnt,
  input logic [15:0] t1_cnt,
  input logic        flag0,
  input logic        flag1,
  input logic        t1_ovf
);

  assert_reset_state_R1: assert property (@(posedge clk)
    !rst_n |=> (t0_cnt == 16'd0 && t1_cnt == 16'd0 && !flag0 && !flag1 && !t1_ovf));

  assert_load_R12: assert property (@(posedge clk) disable iff (!rst_n)
    ld0 |=> t0_cnt == $past(ld_val));

  assert_hold_stopped_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (t0_mode != 2'd3 && !t0_run && !ld0) |=> $stable(t0_cnt));

  assert_flag_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (flag0 && !clr_f0) |=> flag0);

  assert_hi_byte_owner_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(flag1) && $past(t0_mode) == 2'd3) |-> $past(t1_run));

  assert_pulse_sets_flag_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (t1_ovf && $past(t0_mode) != 2'd3) |-> flag1);

endmodule

bind split_timer_pair split_timer_pair_chk u_chk (.*);

// File: tb/tb_split_timer_pair.sv
module tb_split_timer_pair;
  logic clk = 0, rst_n = 0;
  logic tick_pre = 0, cnt0_pin = 0, cnt1_pin = 0, gate_pin = 0, gate_pol = 0;
  logic [1:0] t0_mode = 1, t1_mode = 1;
  logic t0_run = 0, t0_ext = 0, t0_gate = 0, t0_clksel = 0;
  logic t1_run = 0, t1_ext = 0, t1_clksel = 0;
  logic ld0 = 0, ld1 = 0, clr_f0 = 0, clr_f1 = 0;
  logic [15:0] ld_val = 0;
  logic [15:0] t0_cnt, t1_cnt;
  logic flag0, flag1, t1_ovf;
  int tests = 0, fails = 0, pulses = 0;
  bit done = 0;

  always #5 clk = ~clk;

  split_timer_pair dut (.*);

  always @(negedge clk) if (t1_ovf) pulses++;

  // sel, mode, start, cycles, expected count, expected flag
  localparam logic [43:0] VEC [0:8] = '{
    {1'b0, 2'd1, 16'hFFFE, 8'd3,  16'h0001, 1'b1},
    {1'b0, 2'd1, 16'h1234, 8'd5,  16'h1239, 1'b0},
    {1'b0, 2'd0, 16'h001E, 8'd3,  16'h0101, 1'b0},
    {1'b0, 2'd0, 16'hFFFF, 8'd1,  16'h00E0, 1'b1},
    {1'b0, 2'd2, 16'h80FE, 8'd3,  16'h8081, 1'b1},
    {1'b0, 2'd2, 16'hF0F0, 8'd40, 16'hF0F8, 1'b1},
    {1'b1, 2'd1, 16'hFFFF, 8'd2,  16'h0001, 1'b1},
    {1'b1, 2'd2, 16'h0AFF, 8'd1,  16'h0A0A, 1'b1},
    {1'b1, 2'd0, 16'h0000, 8'd33, 16'h0101, 1'b0}
  };

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic load(input bit sel, input logic [15:0] v);
    @(negedge clk);
    t0_run = 0; t1_run = 0;
    ld0 = !sel; ld1 = sel; ld_val = v; clr_f0 = 1; clr_f1 = 1;
    @(negedge clk);
    ld0 = 0; ld1 = 0; clr_f0 = 0; clr_f1 = 0;
  endtask

  task automatic pin_pulses(input int k, input bit which);
    for (int i = 0; i < k; i++) begin
      if (which) cnt1_pin = 1; else cnt0_pin = 1;
      repeat (3) @(negedge clk);
      cnt0_pin = 0; cnt1_pin = 0;
      repeat (3) @(negedge clk);
    end
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    repeat (3) @(negedge clk);
    chk("R1 t0_cnt", t0_cnt, 0); chk("R1 t1_cnt", t1_cnt, 0);
    chk("R1 flags", {flag0, flag1, t1_ovf}, 0);
    rst_n = 1;

    // R2 R3 R4 R13 vector table
    pulses = 0;
    for (int i = 0; i <= 8; i++) begin
      logic [43:0] v;
      v = VEC[i];
      t0_mode = v[42:41]; t1_mode = v[42:41];
      load(v[43], v[40:25]);
      if (v[43]) t1_run = 1; else t0_run = 1;
      repeat (v[24:17]) @(posedge clk);
      @(negedge clk);
      chk($sformatf("R2/R3/R4 vec%0d count", i), v[43] ? t1_cnt : t0_cnt, v[16:1]);
      chk($sformatf("R2/R3/R4 vec%0d flag", i), v[43] ? flag1 : flag0, v[0]);
      t0_run = 0; t1_run = 0;
    end
    chk("R13 pulse count", pulses, 2);

    // R8 split low byte
    t0_mode = 3; t1_mode = 3;
    load(0, 16'h10FE);
    t0_run = 1;
    repeat (3) @(posedge clk); @(negedge clk);
    chk("R8 split low count", t0_cnt, 16'h1001);
    chk("R8 flag0", flag0, 1); chk("R8 flag1", flag1, 0);

    // R9 split high byte on t1_run
    load(0, 16'hFE05);
    t1_run = 1;
    repeat (3) @(posedge clk); @(negedge clk);
    chk("R9 split high count", t0_cnt, 16'h0105);
    chk("R9 flag1", flag1, 1); chk("R9 flag0", flag0, 0);

    // R10 timer 1 silent in split, R13 pulse still produced
    t1_mode = 1; pulses = 0;
    load(1, 16'hFFFE);
    repeat (3) @(posedge clk); @(negedge clk);
    chk("R10 t1 runs without run bit", t1_cnt, 16'h0001);
    chk("R10 no flag1", flag1, 0);
    chk("R13 split pulse", pulses, 1);

    // R10 mode 3 halts timer 1
    t1_mode = 3;
    load(1, 16'h0050);
    t1_run = 1;
    repeat (5) @(posedge clk); @(negedge clk);
    chk("R10 t1 mode3 holds", t1_cnt, 16'h0050);
    t1_run = 0;

    // R10 R6 external count ignored in split, used otherwise
    t1_mode = 1; t1_ext = 1; t1_clksel = 1; tick_pre = 0;
    load(1, 16'h0000);
    pin_pulses(3, 1);
    chk("R10 ext ignored in split", t1_cnt, 0);
    t0_mode = 1;
    load(1, 16'h0000);
    t1_run = 1;
    pin_pulses(3, 1);
    chk("R6 t1 pin edges", t1_cnt, 3);
    t1_run = 0; t1_ext = 0; t1_clksel = 0;

    // R6 timer 0 pin edges
    t0_ext = 1;
    load(0, 16'h0000);
    t0_run = 1;
    pin_pulses(4, 0);
    chk("R6 t0 pin edges", t0_cnt, 4);
    t0_run = 0; t0_ext = 0;

    // R5 gate with polarity
    t0_gate = 1; gate_pol = 0; gate_pin = 0;
    load(0, 16'h0000);
    t0_run = 1;
    repeat (5) @(posedge clk); @(negedge clk);
    chk("R5 gated off", t0_cnt, 0);
    gate_pin = 1;
    repeat (10) @(posedge clk); @(negedge clk);
    chk("R5 gated on", t0_cnt, 8);
    gate_pol = 1;
    repeat (5) @(posedge clk); @(negedge clk);
    chk("R5 polarity inverts", t0_cnt, 8);
    t0_run = 0; t0_gate = 0; gate_pol = 0; gate_pin = 0;

    // R7 prescaled timebase
    t0_clksel = 1;
    load(0, 16'h0000);
    t0_run = 1;
    for (int i = 0; i < 20; i++) begin
      tick_pre = (i % 4 == 0);
      @(negedge clk);
    end
    tick_pre = 0;
    chk("R7 prescaled count", t0_cnt, 5);
    t0_run = 0; t0_clksel = 0;

    // R11 overflow beats clear
    load(0, 16'hFFFF);
    t0_run = 1; @(negedge clk); t0_run = 0;
    chk("R11 flag set", flag0, 1);
    ld0 = 1; ld_val = 16'hFFFF; @(negedge clk); ld0 = 0;
    t0_run = 1; clr_f0 = 1; @(negedge clk);
    t0_run = 0; clr_f0 = 0;
    chk("R11 overflow wins over clear", flag0, 1);
    clr_f0 = 1; @(negedge clk); clr_f0 = 0;
    chk("R11 clear", flag0, 0);

    // R12 load beats counting
    load(0, 16'h0000);
    t0_run = 1;
    repeat (3) @(negedge clk);
    ld0 = 1; ld_val = 16'h4242; @(negedge clk); ld0 = 0; t0_run = 0;
    chk("R12 load precedence", t0_cnt, 16'h4242);
    chk("R12 no flag", flag0, 0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule